// File: doc/BRIEF.md
# Single-Shot Converter Serial Target Model

This block is a synthesizable stand-in for the digital side of a single-shot sigma-delta converter. It is meant for checking host controllers: a host drives chip select, clock and data-in, and the model answers the way such a converter does, including the dual role of its data-out pin as a conversion-ready flag. No analog conversion takes place. A completed conversion produces the next value of a 24-bit pseudo-random sequence, tagged with the channel that was selected.

Every transaction begins with an 8-bit command byte. This byte picks a register and says whether to read it or write it. The data field for that register follows. Writing the single-conversion code into the mode field starts a conversion. The model powers up, waits through a programmable power-up interval and a programmable conversion interval, stores the result, and pulls the ready line low. Reading the data register releases the ready line. If the append option is set, the data word is followed by a status byte that carries the channel tag.

The serial inputs are brought into the system clock domain through a short synchronizer. The host must therefore run its serial clock well below the system clock. Data-in is captured on a rising serial-clock edge. Data-out advances a few system clocks after each rising edge, so the host may sample it on the next rising edge.

Top module: `cnvsim_target`

## Requirements
- R1: The command byte is sent MSB first. Its bit 6 selects read (1) or write (0), and bits 5..3 give the register address. Address 0 is status, 1 is mode and 3 is data. The data field that follows is 24 bits for a mode access. It is 24 bits for a data read, or 32 bits with append set. Every other access uses 8 bits. After that field, the next 8 bits are taken as a new command byte.
- R2: The mode register is 24 bits, written and read MSB first. It has these fields: [23:21] operating code, [20] status append, [19:16] channel, [15:0] kept but without effect. It resets to 0x600000, and a write followed by a read returns the written value.
- R3: Writing operating code 001 starts a conversion. The result is stored PWRUP_US*CLKS_PER_US + CONV_CYCLES clocks later, give or take a few clocks. When it is stored, the operating code reads back as 011 (power-down) and all other mode bits are unchanged.
- R4: Conversion results follow s' = {s[22:0], s[23]^s[22]^s[21]^s[16]}. The first result is one step from LFSR_SEED, and each later conversion takes one more step. The data register is 0 after reset.
- R5: While chip select is low and no read field is being shifted, data-out shows the ready level. That level is high after reset. It goes low when a result is stored, and it returns high once the last bit of a data-register read has been shifted.
- R6: With chip select held low after a data read, the ready level stays high until another conversion completes. Reading the data register again returns the same value.
- R7: With append set, a data read returns the 24-bit result and then the status byte.
- R8: The status byte is {ready level, 3'b000, channel tag of the last stored result}. A status read (address 0) returns it. The tag resets to 0.
- R9: A read of address 2, 4, 5, 6 or 7 returns zeros. A write to any of those addresses leaves the mode register unchanged.
- R10: spi_miso_oe is 0 while chip select is high and 1 while it is low, after the synchronizer delay.
- R11: Raising chip select in the middle of a field drops the partial field. The next transaction starts over with a command byte.
- R12: Writing any operating code other than 001 while a conversion is running cancels it. No result is stored, the ready level does not fall, and the written code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data / ready flag to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso (tri-state model) |

## Verification
The properties check cycle-level invariants on every cycle. The bit counter never passes its field length. A high chip select always returns the framer to the command phase. A stored result is never zero. A conversion begins with power-up, and it can only finish from the conversion state. The ready level can fall only in the cycle after a result is stored. Other behaviour can only be shown by the bench scenarios: the pseudo-random result sequence, the exact bits shifted for each register, the status byte with its channel tag, how long the ready line stays high after a read, cancellation, and recovery after chip select is raised mid-field.

// File: rtl/cnvsim_pkg.sv
package cnvsim_pkg;

    localparam int CMD_BITS  = 8;
    localparam int WORD_BITS = 24;
    localparam int TX_BITS   = 32;

    localparam logic [2:0] A_STATUS = 3'd0;
    localparam logic [2:0] A_MODE   = 3'd1;
    localparam logic [2:0] A_DATA   = 3'd3;

    localparam logic [2:0] MD_SINGLE = 3'b001;
    localparam logic [2:0] MD_PWRDN  = 3'b011;

    typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;
    typedef enum logic [1:0] {CV_IDLE, CV_PWRUP, CV_CONV} conv_e;

    typedef struct packed {
        logic       rd;
        logic [2:0] addr;
    } cmd_t;

    typedef struct packed {
        logic [2:0]  md;
        logic        stat_app;
        logic [3:0]  chan;
        logic [15:0] spare;
    } mode_t;

    localparam logic [23:0] MODE_RESET = 24'h600000;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.rd   = b[6];
        c.addr = b[5:3];
        return c;
    endfunction

    function automatic logic [23:0] lfsr_step(input logic [23:0] s);
        return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
    endfunction

    function automatic logic [5:0] field_bits(input cmd_t c, input logic app);
        logic [5:0] n;
        if (!c.rd) begin
            n = (c.addr == A_MODE) ? 6'd24 : 6'd8;
        end else begin
            case (c.addr)
                A_MODE:  n = 6'd24;
                A_DATA:  n = app ? 6'd32 : 6'd24;
                default: n = 6'd8;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/cnvsim_spi_sync.sv
module cnvsim_spi_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic cs_idle,
    output logic sclk_rise,
    output logic mosi_s
);

    logic [SYNC_STAGES:0]   sclk_p;
    logic [SYNC_STAGES-1:0] cs_p;
    logic [SYNC_STAGES-1:0] mosi_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= '1;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[SYNC_STAGES-1:0], spi_sclk};
            cs_p   <= {cs_p[SYNC_STAGES-2:0], spi_cs_n};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
        end
    end

    assign cs_idle   = cs_p[SYNC_STAGES-1];
    assign mosi_s    = mosi_p[SYNC_STAGES-1];
    assign sclk_rise = sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];

endmodule

// File: rtl/cnvsim_conv_engine.sv
module cnvsim_conv_engine
    import cnvsim_pkg::*;
#(
    parameter int          PWRUP_CYCLES = 200,
    parameter int          CONV_CYCLES  = 64,
    parameter logic [23:0] LFSR_SEED    = 24'h5A3C91
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        abort,
    output logic        done,
    output logic [23:0] result
);

    localparam int MAXC  = (PWRUP_CYCLES > CONV_CYCLES) ? PWRUP_CYCLES : CONV_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] PW_LAST = CNT_W'(PWRUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] CV_LAST = CNT_W'(CONV_CYCLES - 1);

    conv_e            state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CV_IDLE;
            cnt    <= '0;
            done   <= 1'b0;
            result <= LFSR_SEED;
        end else begin
            done <= 1'b0;
            if (start) begin
                state <= CV_PWRUP;
                cnt   <= '0;
            end else if (abort) begin
                state <= CV_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    CV_PWRUP: begin
                        if (cnt == PW_LAST) begin
                            state <= CV_CONV;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    CV_CONV: begin
                        if (cnt == CV_LAST) begin
                            state  <= CV_IDLE;
                            cnt    <= '0;
                            done   <= 1'b1;
                            result <= lfsr_step(result);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    // R3: a result can only appear out of the conversion state
    a_r3_done_after_conv: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state == CV_CONV));

    // R3: a start request always enters power-up first
    a_r3_start_enters_pwrup: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == CV_PWRUP));

    // R4: the sequence never locks up at zero
    a_r4_result_nonzero: assert property (@(posedge clk) disable iff (rst)
        done |-> (result != 24'd0));

endmodule

// File: rtl/cnvsim_target.sv
module cnvsim_target
    import cnvsim_pkg::*;
#(
    parameter int          PWRUP_US    = 200,
    parameter int          CLKS_PER_US = 1,
    parameter int          CONV_CYCLES = 64,
    parameter logic [23:0] LFSR_SEED   = 24'h5A3C91,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);

    localparam int PWRUP_CYCLES = PWRUP_US * CLKS_PER_US;

    logic cs_idle, sclk_rise, mosi_s;

    cnvsim_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .cs_idle   (cs_idle),
        .sclk_rise (sclk_rise),
        .mosi_s    (mosi_s)
    );

    // framing state
    phase_e               phase;
    logic [5:0]           bit_cnt;
    logic [5:0]           field_len;
    logic [WORD_BITS-2:0] sh_in;
    logic [TX_BITS-1:0]   tx_sr;
    logic [2:0]           addr_q;

    // register state
    mode_t       mode_q;
    logic [23:0] data_q;
    logic [3:0]  tag_q;
    logic [3:0]  tag_pend;
    logic        rdy_n_q;

    logic               conv_start, conv_abort, conv_done;
    logic [23:0]        conv_result;
    logic               last_bit, wr_mode_ev, rd_data_ev;
    logic [23:0]        wr_value;
    cmd_t               cmd_now;
    logic [7:0]         status_byte;
    logic [TX_BITS-1:0] rd_word;

    assign last_bit   = (bit_cnt == field_len - 6'd1);
    assign wr_value   = {sh_in, mosi_s};
    assign cmd_now    = decode_cmd({sh_in[6:0], mosi_s});
    assign wr_mode_ev = !cs_idle && sclk_rise && (phase == PH_WR) && last_bit && (addr_q == A_MODE);
    assign rd_data_ev = !cs_idle && sclk_rise && (phase == PH_RD) && last_bit && (addr_q == A_DATA);
    assign conv_start = wr_mode_ev && (wr_value[23:21] == MD_SINGLE);
    assign conv_abort = wr_mode_ev && (wr_value[23:21] != MD_SINGLE);

    assign status_byte = {rdy_n_q, 3'b000, tag_q};

    always_comb begin
        case (cmd_now.addr)
            A_MODE:   rd_word = {mode_q, 8'h00};
            A_DATA:   rd_word = mode_q.stat_app ? {data_q, status_byte} : {data_q, 8'h00};
            A_STATUS: rd_word = {status_byte, 24'h000000};
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            field_len <= 6'd8;
            sh_in     <= '0;
            tx_sr     <= '0;
            addr_q    <= '0;
        end else if (cs_idle) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            case (phase)
                PH_CMD: begin
                    sh_in <= {sh_in[WORD_BITS-3:0], mosi_s};
                    if (bit_cnt == 6'(CMD_BITS - 1)) begin
                        bit_cnt   <= '0;
                        addr_q    <= cmd_now.addr;
                        field_len <= field_bits(cmd_now, mode_q.stat_app);
                        if (cmd_now.rd) begin
                            phase <= PH_RD;
                            tx_sr <= rd_word;
                        end else begin
                            phase <= PH_WR;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 6'd1;
                    end
                end
                PH_WR: begin
                    sh_in <= {sh_in[WORD_BITS-3:0], mosi_s};
                    if (last_bit) begin
                        phase   <= PH_CMD;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 6'd1;
                    end
                end
                default: begin
                    tx_sr <= {tx_sr[TX_BITS-2:0], 1'b0};
                    if (last_bit) begin
                        phase   <= PH_CMD;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 6'd1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= mode_t'(MODE_RESET);
            data_q   <= '0;
            tag_q    <= '0;
            tag_pend <= '0;
            rdy_n_q  <= 1'b1;
        end else begin
            if (wr_mode_ev) begin
                mode_q <= mode_t'(wr_value);
                if (conv_start) begin
                    tag_pend <= wr_value[19:16];
                    rdy_n_q  <= 1'b1;
                end
            end
            if (rd_data_ev) begin
                rdy_n_q <= 1'b1;
            end
            if (conv_done) begin
                data_q  <= conv_result;
                tag_q   <= tag_pend;
                rdy_n_q <= 1'b0;
                if (!wr_mode_ev) begin
                    mode_q.md <= MD_PWRDN;
                end
            end
        end
    end

    cnvsim_conv_engine #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .CONV_CYCLES  (CONV_CYCLES),
        .LFSR_SEED    (LFSR_SEED)
    ) u_conv (
        .clk    (clk),
        .rst    (rst),
        .start  (conv_start),
        .abort  (conv_abort),
        .done   (conv_done),
        .result (conv_result)
    );

    assign spi_miso    = (phase == PH_RD) ? tx_sr[TX_BITS-1] : rdy_n_q;
    assign spi_miso_oe = ~cs_idle;

    // R1: a field never runs past its length
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_CMD) |-> (bit_cnt < field_len));

    // R11: chip select high always leaves the framer waiting for a command byte
    a_r11_cs_idle_resets_frame: assert property (@(posedge clk) disable iff (rst)
        $past(cs_idle) |-> (phase == PH_CMD && bit_cnt == 6'd0));

    // R5: the ready level only falls right after a result is stored
    a_r5_ready_falls_only_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n_q) |-> $past(conv_done));

endmodule

// File: tb/cnvsim_target_tb.sv
module cnvsim_target_tb;

    localparam int          PWRUP_US    = 200;
    localparam int          CLKS_PER_US = 2;
    localparam int          CONV_CYCLES = 64;
    localparam logic [23:0] SEED        = 24'h5A3C91;
    localparam int          HALF        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b1;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [23:0] exp_state = SEED;

    always #2.5 clk = ~clk;

    cnvsim_target #(
        .PWRUP_US    (PWRUP_US),
        .CLKS_PER_US (CLKS_PER_US),
        .CONV_CYCLES (CONV_CYCLES),
        .LFSR_SEED   (SEED)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    function automatic logic [23:0] seq_next(input logic [23:0] s);
        logic fb;
        fb = s[23] ^ s[22] ^ s[21] ^ s[16];
        return (s << 1) | {23'd0, fb};
    endfunction

    function automatic logic [23:0] mk_mode(input logic [2:0] md, input logic app,
                                            input logic [3:0] ch, input logic [15:0] sp);
        return {md, app, ch, sp};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input int n, input logic [31:0] tx, output logic [31:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx = {rx[30:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic cs_lo();
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_hi();
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input int n, input logic [31:0] v);
        logic [31:0] d;
        xfer(8, {24'd0, 2'b00, a, 3'b000}, d);
        xfer(n, v, d);
    endtask

    task automatic reg_read(input logic [2:0] a, input int n, output logic [31:0] v);
        logic [31:0] d;
        xfer(8, {24'd0, 2'b01, a, 3'b000}, d);
        xfer(n, 32'd0, v);
    endtask

    task automatic frame_write(input logic [2:0] a, input int n, input logic [31:0] v);
        cs_lo(); reg_write(a, n, v); cs_hi();
    endtask

    task automatic frame_read(input logic [2:0] a, input int n, output logic [31:0] v);
        cs_lo(); reg_read(a, n, v); cs_hi();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [23:0] mv, cur_mode;
        int seed_dummy;
        seed_dummy = $urandom(17);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // reset state
        check("R10 oe with cs high", {31'd0, spi_miso_oe}, 32'd0);
        frame_read(3'd1, 24, rv);
        check("R2 mode reset", rv, 32'h600000);
        frame_read(3'd3, 24, rv);
        check("R4 data reset", rv, 32'd0);
        frame_read(3'd0, 8, rv);
        check("R8 status reset", rv, 32'h80);
        cs_lo();
        check("R10 oe with cs low", {31'd0, spi_miso_oe}, 32'd1);
        check("R5 ready idle high", {31'd0, spi_miso}, 32'd1);
        cs_hi();

        // random mode writes without starting conversions
        for (int k = 0; k < 6; k++) begin
            mv = 24'($urandom);
            if (mv[23:21] == 3'b001) mv[23:21] = 3'b000;
            frame_write(3'd1, 24, {8'd0, mv});
            frame_read(3'd1, 24, rv);
            check("R2 mode readback", rv, {8'd0, mv});
        end
        cur_mode = mv;

        // unsupported addresses
        for (int a = 4; a < 8; a++) begin
            frame_write(3'(a), 8, 32'($urandom) & 32'hFF);
            frame_read(3'(a), 8, rv);
            check("R9 unsupported read zero", rv, 32'd0);
        end
        frame_write(3'd2, 8, 32'hFF);
        frame_read(3'd2, 8, rv);
        check("R9 address 2 read zero", rv, 32'd0);
        frame_read(3'd1, 24, rv);
        check("R9 mode unchanged", rv, {8'd0, cur_mode});

        // R11: chip select raised after 4 bits of a command
        cs_lo();
        xfer(4, 32'hF, rv);
        cs_hi();
        frame_read(3'd1, 24, rv);
        check("R11 frame restart", rv, {8'd0, cur_mode});

        // single conversion with timing window, no append
        mv = mk_mode(3'b001, 1'b0, 4'h5, 16'hBEEF);
        cs_lo();
        reg_write(3'd1, 24, {8'd0, mv});
        repeat (400) @(negedge clk);
        check("R3 ready high before conversion ends", {31'd0, spi_miso}, 32'd1);
        repeat (80) @(negedge clk);
        check("R5 ready low after conversion", {31'd0, spi_miso}, 32'd0);
        reg_read(3'd1, 24, rv);
        check("R3 mode back to power-down", rv, {8'd0, mk_mode(3'b011, 1'b0, 4'h5, 16'hBEEF)});
        check("R5 ready still low after mode read", {31'd0, spi_miso}, 32'd0);
        exp_state = seq_next(exp_state);
        reg_read(3'd3, 24, rv);
        check("R4 first result", rv, {8'd0, exp_state});
        check("R5 ready high after data read", {31'd0, spi_miso}, 32'd1);
        repeat (600) @(negedge clk);
        check("R6 ready held high with cs low", {31'd0, spi_miso}, 32'd1);
        reg_read(3'd3, 24, rv);
        check("R6 reread same value", rv, {8'd0, exp_state});
        reg_read(3'd0, 8, rv);
        check("R8 status after read", rv, 32'h85);
        cs_hi();

        // append mode
        mv = mk_mode(3'b001, 1'b1, 4'hA, 16'h0123);
        frame_write(3'd1, 24, {8'd0, mv});
        repeat (520) @(negedge clk);
        exp_state = seq_next(exp_state);
        cs_lo();
        reg_read(3'd3, 32, rv);
        check("R7 data plus status", rv, {exp_state, 8'h0A});
        check("R5 ready high after appended read", {31'd0, spi_miso}, 32'd1);
        reg_read(3'd3, 32, rv);
        check("R7 reread status shows ready high", rv, {exp_state, 8'h8A});
        cs_hi();

        // R12: cancel a running conversion
        frame_write(3'd1, 24, {8'd0, mk_mode(3'b001, 1'b0, 4'h3, 16'h0000)});
        frame_write(3'd1, 24, {8'd0, mk_mode(3'b000, 1'b0, 4'h3, 16'h0000)});
        cs_lo();
        repeat (600) @(negedge clk);
        check("R12 no ready after cancel", {31'd0, spi_miso}, 32'd1);
        reg_read(3'd3, 24, rv);
        check("R12 data unchanged after cancel", rv, {8'd0, exp_state});
        reg_read(3'd1, 24, rv);
        check("R12 written code kept", rv, {8'd0, mk_mode(3'b000, 1'b0, 4'h3, 16'h0000)});
        cs_hi();

        // random conversions
        for (int k = 0; k < 3; k++) begin
            logic [3:0] ch;
            logic       app;
            ch  = 4'($urandom);
            app = 1'($urandom);
            frame_write(3'd1, 24, {8'd0, mk_mode(3'b001, app, ch, 16'($urandom))});
            repeat (520) @(negedge clk);
            exp_state = seq_next(exp_state);
            if (app) begin
                frame_read(3'd3, 32, rv);
                check("R4 R7 random appended result", rv, {exp_state, 4'h0, ch});
            end else begin
                frame_read(3'd3, 24, rv);
                check("R4 random result", rv, {8'd0, exp_state});
            end
            frame_read(3'd0, 8, rv);
            check("R8 random status tag", rv, {24'd0, 4'h8, ch});
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule